// File: doc/BRIEF.md
# Macroblock Raster Address Generator

This block produces the read addresses that a block-matching or transform engine needs to fetch a frame from a linear, line-major pixel memory one 16x16 macroblock at a time. Within a block it walks the pixels left to right, line by line. When a block is finished it moves to the next block to the right in the same 16-line strip. After the rightmost block of a strip it drops to the first block of the next strip.

One address is issued per clock while the enable input is high. Lowering enable freezes the walk where it stands. The current block column and row are exposed alongside the address. Strobes mark the first pixel of a block, the last pixel of a block and the last pixel of the frame. After the last pixel of the frame the generator goes quiet and stays that way until the next synchronous reset.

Top module: `mb_addr_gen`

## Requirements
- R1: While `rst` is high, `addr_valid`, `blk_start`, `blk_done` and `frame_done` are low. On the first enabled cycle after reset, the address is 0, the block column and row are 0, and `blk_start` is high.
- R2: Each valid address equals (blk_row*16 + y)*FRAME_W + blk_col*16 + x, where x and y are the pixel column and line inside the block, each 0..15.
- R3: Inside a block, x advances by one per issued address. When x wraps from 15 to 0, y advances by one.
- R4: `blk_start` is high exactly on the issued address with x = 0 and y = 0.
- R5: `blk_done` is high exactly on the 256th issued address of a block (x = 15, y = 15). The next issued address is the first pixel of the following block.
- R6: The block column advances only after a block completes. The block row advances only when the column wraps from its last value to 0. The first address of strip 1 is 16*FRAME_W.
- R7: While `en` is low, `addr_valid` and all strobes are low, and the address, block column and block row hold their values. The walk resumes from the same pixel when `en` returns high.
- R8: `frame_done` is high only on the last address of the last block, FRAME_W*FRAME_H-1. From the next cycle on, `addr_valid` stays low until reset.
- R9: A frame issues exactly FRAME_W*FRAME_H valid addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Issue one address this cycle when high |
| addr | output | $clog2(FRAME_W*FRAME_H) | Linear pixel address |
| addr_valid | output | 1 | The address on `addr` is issued this cycle |
| blk_col | output | clog2 of block columns | Current block column |
| blk_row | output | clog2 of block rows | Current block row |
| blk_start | output | 1 | First pixel of a block |
| blk_done | output | 1 | Last pixel of a block |
| frame_done | output | 1 | Last pixel of the frame |

## Verification
The address is formed combinationally from the counters in every cycle, so a counter that steps wrongly or holds wrongly shows up as a wrong address in the very next enabled cycle. A misplaced wrap of the pixel line or of the block column shows up as a jump of FRAME_W or 16 at a block or strip boundary. It also shifts when `blk_done` and `frame_done` appear, and the frame then issues too many or too few addresses. A freeze fault under a low `en` shows up as an address that differs from the held one during the gap.

// File: rtl/mbag_pkg.sv
package mbag_pkg;
    localparam int MB_LOG2 = 4;
    localparam int MB_SIDE = 1 << MB_LOG2;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_DONE = 1'b1
    } gen_state_e;
endpackage

// File: rtl/mbag_pix_cnt.sv
module mbag_pix_cnt
    import mbag_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               step,
    output logic [MB_LOG2-1:0] px,
    output logic [MB_LOG2-1:0] py,
    output logic               blk_last
);
    typedef struct packed {
        logic [MB_LOG2-1:0] x;
        logic [MB_LOG2-1:0] y;
    } pix_t;

    pix_t pix_d, pix_q;

    always_comb begin
        pix_d = pix_q;
        if (step) begin
            if (pix_q.x == MB_LOG2'(MB_SIDE - 1)) begin
                pix_d.x = '0;
                pix_d.y = pix_q.y + 1'b1;
            end else begin
                pix_d.x = pix_q.x + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pix_q <= '0;
        else     pix_q <= pix_d;
    end

    assign px       = pix_q.x;
    assign py       = pix_q.y;
    assign blk_last = (pix_q.x == MB_LOG2'(MB_SIDE - 1)) && (pix_q.y == MB_LOG2'(MB_SIDE - 1));

    assert_x_steps_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(step) && ($past(px) != MB_LOG2'(MB_SIDE - 1))) |-> (px == $past(px) + 1'b1 && py == $past(py)));

    assert_line_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(step) && ($past(px) == MB_LOG2'(MB_SIDE - 1)) && ($past(py) != MB_LOG2'(MB_SIDE - 1)))
        |-> (px == '0 && py == $past(py) + 1'b1));

    assert_block_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (step && blk_last) |=> (px == '0 && py == '0));

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !step |=> ($stable(px) && $stable(py)));
endmodule

// File: rtl/mbag_blk_cnt.sv
module mbag_blk_cnt #(
    parameter int COLS = 40,
    parameter int ROWS = 30,
    localparam int CW = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    output logic [CW-1:0] bc,
    output logic [RW-1:0] br,
    output logic          frame_last
);
    localparam logic [CW-1:0] LAST_C = CW'(COLS - 1);
    localparam logic [RW-1:0] LAST_R = RW'(ROWS - 1);

    typedef struct packed {
        logic [CW-1:0] c;
        logic [RW-1:0] r;
    } blk_t;

    blk_t blk_d, blk_q;

    always_comb begin
        blk_d = blk_q;
        if (step) begin
            if (blk_q.c == LAST_C) begin
                blk_d.c = '0;
                blk_d.r = (blk_q.r == LAST_R) ? '0 : blk_q.r + 1'b1;
            end else begin
                blk_d.c = blk_q.c + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) blk_q <= '0;
        else     blk_q <= blk_d;
    end

    assign bc         = blk_q.c;
    assign br         = blk_q.r;
    assign frame_last = (blk_q.c == LAST_C) && (blk_q.r == LAST_R);

    assert_col_steps_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(step) && ($past(bc) != LAST_C)) |-> (bc == $past(bc) + 1'b1 && br == $past(br)));

    assert_strip_steps_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(step) && ($past(bc) == LAST_C) && ($past(br) != LAST_R)) |-> (bc == '0 && br == $past(br) + 1'b1));

    assert_row_holds_R6: assert property (@(posedge clk) disable iff (rst)
        !step |=> ($stable(bc) && $stable(br)));
endmodule

// File: rtl/mb_addr_gen.sv
module mb_addr_gen
    import mbag_pkg::*;
#(
    parameter int FRAME_W = 640,
    parameter int FRAME_H = 480,
    localparam int BLK_COLS = FRAME_W >> MB_LOG2,
    localparam int BLK_ROWS = FRAME_H >> MB_LOG2,
    localparam int CW = (BLK_COLS > 1) ? $clog2(BLK_COLS) : 1,
    localparam int RW = (BLK_ROWS > 1) ? $clog2(BLK_ROWS) : 1,
    localparam int ADDR_W = $clog2(FRAME_W * FRAME_H)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    output logic [ADDR_W-1:0] addr,
    output logic              addr_valid,
    output logic [CW-1:0]     blk_col,
    output logic [RW-1:0]     blk_row,
    output logic              blk_start,
    output logic              blk_done,
    output logic              frame_done
);
    typedef struct packed {
        gen_state_e st;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [MB_LOG2-1:0] px, py;
    logic               pix_last, blk_last, blk_step;
    logic [RW+MB_LOG2-1:0] line_idx;
    logic [CW+MB_LOG2-1:0] col_idx;

    assign addr_valid = !rst && en && (ctl_q.st == ST_RUN);
    assign blk_step   = addr_valid && pix_last;

    mbag_pix_cnt u_pix (
        .clk      (clk),
        .rst      (rst),
        .step     (addr_valid),
        .px       (px),
        .py       (py),
        .blk_last (pix_last)
    );

    mbag_blk_cnt #(
        .COLS (BLK_COLS),
        .ROWS (BLK_ROWS)
    ) u_blk (
        .clk        (clk),
        .rst        (rst),
        .step       (blk_step),
        .bc         (blk_col),
        .br         (blk_row),
        .frame_last (blk_last)
    );

    assign line_idx   = {blk_row, py};
    assign col_idx    = {blk_col, px};
    assign addr       = ADDR_W'(line_idx) * ADDR_W'(FRAME_W) + ADDR_W'(col_idx);
    assign blk_start  = addr_valid && (px == '0) && (py == '0);
    assign blk_done   = blk_step;
    assign frame_done = blk_step && blk_last;

    always_comb begin
        ctl_d = ctl_q;
        if (frame_done) ctl_d.st = ST_DONE;
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '{st: ST_RUN};
        else     ctl_q <= ctl_d;
    end

    assert_first_addr_R1: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && en) |-> (addr == '0 && blk_start));

    assert_freeze_R7: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(addr) && $stable(blk_col) && $stable(blk_row)));

    assert_quiet_after_frame_R8: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !addr_valid);

    assert_stay_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !addr_valid && $past(frame_done) |=> !addr_valid);

    assert_frame_end_addr_R8: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> (addr == ADDR_W'(FRAME_W * FRAME_H - 1)));
endmodule

// File: tb/mb_addr_gen_test.sv
module mb_addr_gen_test;
    localparam int PERIOD = 10;
    localparam int W = 64;
    localparam int H = 48;
    localparam int NBC = W / 16;
    localparam int NBR = H / 16;
    localparam int AW = $clog2(W * H);

    typedef struct packed {
        logic        en;
        logic        v;
        logic [15:0] a;
        logic        s;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b1, 1'b1, 16'd0, 1'b1},
        '{1'b1, 1'b1, 16'd1, 1'b0},
        '{1'b0, 1'b0, 16'd2, 1'b0},
        '{1'b0, 1'b0, 16'd2, 1'b0},
        '{1'b1, 1'b1, 16'd2, 1'b0},
        '{1'b1, 1'b1, 16'd3, 1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic [AW-1:0] addr;
    logic addr_valid, blk_start, blk_done, frame_done;
    logic [1:0] blk_col, blk_row;

    int n_chk = 0;
    int n_fail = 0;
    int mx, my, mbc, mbr, mdone, issued;

    mb_addr_gen #(.FRAME_W(W), .FRAME_H(H)) uut (
        .clk(clk), .rst(rst), .en(en), .addr(addr), .addr_valid(addr_valid),
        .blk_col(blk_col), .blk_row(blk_row), .blk_start(blk_start),
        .blk_done(blk_done), .frame_done(frame_done)
    );

    always #(PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic r, input logic e);
        @(negedge clk);
        rst = r;
        en  = e;
        #1;
    endtask

    task automatic model_reset();
        mx = 0; my = 0; mbc = 0; mbr = 0; mdone = 0; issued = 0;
    endtask

    task automatic check_model();
        int ev, eaddr, es, ed;
        ev    = (!rst && en && !mdone) ? 1 : 0;
        eaddr = (mbr * 16 + my) * W + mbc * 16 + mx;
        es    = (ev && mx == 0 && my == 0) ? 1 : 0;
        ed    = (ev && mx == 15 && my == 15) ? 1 : 0;
        chk("R1/R7/R8 valid", int'(addr_valid), ev);
        chk("R4 blk_start", int'(blk_start), es);
        chk("R5 blk_done", int'(blk_done), ed);
        chk("R8 frame_done", int'(frame_done), (ed && mbc == NBC - 1 && mbr == NBR - 1) ? 1 : 0);
        if (!mdone) begin
            chk("R2/R3/R7 addr", int'(addr), eaddr);
            chk("R6 blk_col", int'(blk_col), mbc);
            chk("R6 blk_row", int'(blk_row), mbr);
        end
        if (es && mbc == 0 && mbr == 1) chk("R6 strip1 start", int'(addr), 16 * W);
        if (ed && mbc == NBC - 1 && mbr == NBR - 1) chk("R8 last addr", int'(addr), W * H - 1);
        if (ev) begin
            issued++;
            if (ed && mbc == NBC - 1 && mbr == NBR - 1) mdone = 1;
            if (mx == 15) begin
                mx = 0;
                if (my == 15) begin
                    my = 0;
                    if (mbc == NBC - 1) begin
                        mbc = 0;
                        mbr = (mbr == NBR - 1) ? 0 : mbr + 1;
                    end else mbc++;
                end else my++;
            end else mx++;
        end
    endtask

    initial begin
        #(PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        model_reset();
        // R1: reset keeps everything quiet even with en high
        for (int i = 0; i < 3; i++) begin
            drive(1'b1, 1'b1);
            chk("R1 valid in reset", int'(addr_valid), 0);
            chk("R1 start in reset", int'(blk_start), 0);
            chk("R1 done in reset", int'(blk_done) + int'(frame_done), 0);
        end
        // Vector table: first addresses with an enable gap (R1, R7)
        for (int i = 0; i < 6; i++) begin
            drive(1'b0, VECS[i].en);
            chk("R7 vec valid", int'(addr_valid), int'(VECS[i].v));
            chk("R2 vec addr", int'(addr), int'(VECS[i].a));
            chk("R1 vec start", int'(blk_start), int'(VECS[i].s));
            check_model();
        end
        // Whole frame with a periodic enable gap (R2..R9)
        for (int k = 0; k < 8000 && !mdone; k++) begin
            drive(1'b0, (k % 7) != 3);
            check_model();
        end
        chk("R9 address count", issued, W * H);
        chk("R8 reached end", mdone, 1);
        // R8: stays quiet after the frame
        for (int i = 0; i < 5; i++) begin
            drive(1'b0, 1'b1);
            chk("R8 quiet after frame", int'(addr_valid), 0);
            chk("R8 no strobes", int'(blk_start) + int'(blk_done) + int'(frame_done), 0);
        end
        // Reset then restart: crosses into the second block (R1, R5)
        drive(1'b1, 1'b1);
        chk("R1 valid in reset", int'(addr_valid), 0);
        model_reset();
        drive(1'b0, 1'b1);
        chk("R1 restart addr", int'(addr), 0);
        chk("R1 restart start", int'(blk_start), 1);
        check_model();
        for (int k = 0; k < 300; k++) begin
            drive(1'b0, 1'b1);
            if (k == 255) begin
                chk("R5 next block addr", int'(addr), 16);
                chk("R5 next block col", int'(blk_col), 1);
            end
            check_model();
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule